// File: doc/BRIEF.md
# Free-Hole Allocation Selector

This block keeps a small table of free memory holes, each entry holding a start address, a length and a valid bit. An allocation request carries a size `n` and a placement policy. The block then walks the table one entry per clock and picks a hole of at least `n` units under that policy. It returns the start address of the chosen hole, or raises a fail flag if no hole is large enough. The chosen hole is then trimmed from its low end, so the leftover stays in the table as a smaller hole. If nothing is left over, the entry is dropped.

A separate return port puts a freed region back into the lowest empty slot of the table. When every slot is in use, the return is refused and an overflow flag is raised. Requests and returns are both accepted only while the block is idle. The control is a three-state machine. IDLE accepts a request (IDLE to SCAN) and takes returns. SCAN examines entry `idx` each cycle. It moves to GRANT either on a first-fit match or after the last entry. GRANT drives a one-cycle grant, writes the trimmed hole back, and returns to IDLE.

Top module: `hole_alloc`

## Requirements
- R1: After reset the table holds no holes, `req_ready` and `ret_ready` are 1, and `gnt_valid` is 0.
- R2: A hole is eligible only when it is valid and its length is at least the requested size. If no hole is eligible after a full scan of DEPTH entries, `gnt_valid` pulses with `gnt_fail`=1, and the table is left unchanged.
- R3: Policy code 0 (first-fit) grants the lowest-index eligible hole. Scanning stops at that match, and `gnt_valid` rises k+1 clock edges after the accepting edge, where k is the slot index of the match.
- R4: Policy code 1 (best-fit) grants the eligible hole with the smallest length. It always scans all DEPTH entries, so `gnt_valid` rises DEPTH edges after the accepting edge.
- R5: Policy code 2 (worst-fit) grants the eligible hole with the largest length, also after a full scan of DEPTH edges. Code 3 behaves as first-fit.
- R6: When best-fit or worst-fit finds equal lengths, the lower slot index wins.
- R7: A grant returns the hole's start address on `gnt_base`. The hole becomes (start+n, length-n), and it is removed when length-n is 0.
- R8: While idle, an accepted return (`ret_valid` with `ret_ready`) writes its hole into the lowest-index empty slot.
- R9: A return that arrives while all DEPTH slots are valid raises `ret_overflow` in the same cycle and does not change the table.
- R10: `req_ready` and `ret_ready` are 0 from the accepting edge until the grant cycle ends. Requests and returns offered in that window are ignored, and `gnt_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request offered |
| req_ready | output | 1 | Block idle; request taken when both are high |
| req_size | input | SIZE_W | Requested size n |
| req_policy | input | 2 | 0 first-fit, 1 best-fit, 2 worst-fit, 3 first-fit |
| gnt_valid | output | 1 | One-cycle grant result |
| gnt_fail | output | 1 | No hole fits (valid with gnt_valid) |
| gnt_base | output | ADDR_W | Start address of the granted hole |
| ret_valid | input | 1 | Freed hole offered |
| ret_ready | output | 1 | Return port accepts (idle) |
| ret_base | input | ADDR_W | Start address of the freed hole |
| ret_size | input | SIZE_W | Length of the freed hole |
| ret_overflow | output | 1 | Return refused because the table is full |

## Verification
On every cycle, the assertions check the handshake timing: the grant is a single pulse, a fail only appears with a grant, the block becomes busy after an accepted request and is ready again after a grant, and a busy window never lasts longer than DEPTH+1 cycles. Overflow is checked to occur only on an accepted return. Which hole is picked under each policy, how ties are broken, how holes are trimmed or removed, which slot an insert lands in, and the fact that failed or refused operations leave the table untouched can only be shown by the bench. It does this through sequences of grants whose addresses and latencies reveal the table contents.

// File: rtl/hole_alloc_pkg.sv
package hole_alloc_pkg;

    typedef enum logic [1:0] {
        POL_FIRST = 2'd0,
        POL_BEST  = 2'd1,
        POL_WORST = 2'd2,
        POL_ALT   = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_GRANT = 2'd2
    } state_e;

endpackage

// File: rtl/hole_alloc_table.sv
module hole_alloc_table #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_base,
    output logic [SIZE_W-1:0] rd_size,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_base,
    input  logic [SIZE_W-1:0] ins_size,
    input  logic              upd_en,
    input  logic              upd_kill,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [ADDR_W-1:0] upd_base,
    input  logic [SIZE_W-1:0] upd_size,
    output logic              full
);

    logic [DEPTH-1:0]  vld_q;
    logic [ADDR_W-1:0] base_q [DEPTH];
    logic [SIZE_W-1:0] size_q [DEPTH];
    logic [IDX_W-1:0]  free_idx;

    // Lowest empty slot: walk downward so the lowest index is written last.
    always_comb begin
        free_idx = '0;
        full     = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_idx = IDX_W'(i);
                full     = 1'b0;
            end
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_base  = base_q[rd_idx];
    assign rd_size  = size_q[rd_idx];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[g]  <= 1'b0;
                    base_q[g] <= '0;
                    size_q[g] <= '0;
                end else if (ins_en && !full && free_idx == IDX_W'(g)) begin
                    vld_q[g]  <= 1'b1;
                    base_q[g] <= ins_base;
                    size_q[g] <= ins_size;
                end else if (upd_en && upd_idx == IDX_W'(g)) begin
                    vld_q[g]  <= !upd_kill;
                    base_q[g] <= upd_base;
                    size_q[g] <= upd_size;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hole_alloc_pick.sv
module hole_alloc_pick
    import hole_alloc_pkg::*;
#(
    parameter int SIZE_W = 16
) (
    input  policy_e           policy,
    input  logic [SIZE_W-1:0] need,
    input  logic              ent_valid,
    input  logic [SIZE_W-1:0] ent_size,
    input  logic              have_pick,
    input  logic [SIZE_W-1:0] pick_size,
    output logic              take
);

    logic eligible;

    assign eligible = ent_valid && (ent_size >= need);

    // Strict comparisons keep the earlier (lower-index) pick on a tie.
    always_comb begin
        unique case (policy)
            POL_BEST:  take = eligible && (!have_pick || ent_size < pick_size);
            POL_WORST: take = eligible && (!have_pick || ent_size > pick_size);
            default:   take = eligible && !have_pick;
        endcase
    end

endmodule

// File: rtl/hole_alloc.sv
module hole_alloc
    import hole_alloc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [1:0]        req_policy,
    output logic              gnt_valid,
    output logic              gnt_fail,
    output logic [ADDR_W-1:0] gnt_base,
    input  logic              ret_valid,
    output logic              ret_ready,
    input  logic [ADDR_W-1:0] ret_base,
    input  logic [SIZE_W-1:0] ret_size,
    output logic              ret_overflow
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    state_e            state_q, state_d;
    policy_e           pol_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SIZE_W-1:0] need_q;
    logic              found_q;
    logic [IDX_W-1:0]  pick_idx_q;
    logic [ADDR_W-1:0] pick_base_q;
    logic [SIZE_W-1:0] pick_size_q;

    logic              ent_valid;
    logic [ADDR_W-1:0] ent_base;
    logic [SIZE_W-1:0] ent_size;
    logic              take;
    logic              full;
    logic              ins_en;
    logic              upd_en;
    logic              upd_kill;
    logic              accept;

    hole_alloc_table #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .SIZE_W(SIZE_W)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (idx_q),
        .rd_valid(ent_valid),
        .rd_base (ent_base),
        .rd_size (ent_size),
        .ins_en  (ins_en),
        .ins_base(ret_base),
        .ins_size(ret_size),
        .upd_en  (upd_en),
        .upd_kill(upd_kill),
        .upd_idx (pick_idx_q),
        .upd_base(pick_base_q + ADDR_W'(need_q)),
        .upd_size(pick_size_q - need_q),
        .full    (full)
    );

    hole_alloc_pick #(
        .SIZE_W(SIZE_W)
    ) pick_i (
        .policy   (pol_q),
        .need     (need_q),
        .ent_valid(ent_valid),
        .ent_size (ent_size),
        .have_pick(found_q),
        .pick_size(pick_size_q),
        .take     (take)
    );

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign ins_en   = ret_valid && (state_q == ST_IDLE);
    assign upd_en   = (state_q == ST_GRANT) && found_q;
    assign upd_kill = (pick_size_q == need_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SCAN;
            ST_SCAN: begin
                if (take && (pol_q == POL_FIRST || pol_q == POL_ALT)) state_d = ST_GRANT;
                else if (idx_q == LAST_IDX)                           state_d = ST_GRANT;
            end
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and scan registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pol_q       <= POL_FIRST;
            idx_q       <= '0;
            need_q      <= '0;
            found_q     <= 1'b0;
            pick_idx_q  <= '0;
            pick_base_q <= '0;
            pick_size_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                pol_q   <= policy_e'(req_policy);
                need_q  <= req_size;
                idx_q   <= '0;
                found_q <= 1'b0;
            end else if (state_q == ST_SCAN) begin
                idx_q <= idx_q + IDX_W'(1);
                if (take) begin
                    found_q     <= 1'b1;
                    pick_idx_q  <= idx_q;
                    pick_base_q <= ent_base;
                    pick_size_q <= ent_size;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        ret_ready    = (state_q == ST_IDLE);
        gnt_valid    = (state_q == ST_GRANT);
        gnt_fail     = (state_q == ST_GRANT) && !found_q;
        gnt_base     = (state_q == ST_GRANT && found_q) ? pick_base_q : '0;
        ret_overflow = ins_en && full;
    end

endmodule

// File: rtl/hole_alloc_chk.sv
module hole_alloc_chk #(
    parameter int DEPTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic gnt_valid,
    input logic gnt_fail,
    input logic ret_valid,
    input logic ret_ready,
    input logic ret_overflow
);

    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          busy_cnt <= 0;
        else if (req_ready)  busy_cnt <= 0;
        else                 busy_cnt <= busy_cnt + 1;
    end

    // R10: grant lasts exactly one cycle
    p_gnt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !gnt_valid);

    // R10: an accepted request makes the block busy
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !ret_ready));

    // R10: after a grant the block is ready again
    p_ready_after_gnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> req_ready);

    // R2: fail is only reported together with a grant
    p_fail_with_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_fail |-> gnt_valid);

    // R4: a scan never exceeds DEPTH entries plus the grant cycle
    p_scan_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (busy_cnt < DEPTH + 1));

    // R9: overflow only on an accepted return
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_overflow |-> (ret_valid && ret_ready));

endmodule

bind hole_alloc hole_alloc_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .gnt_valid   (gnt_valid),
    .gnt_fail    (gnt_fail),
    .ret_valid   (ret_valid),
    .ret_ready   (ret_ready),
    .ret_overflow(ret_overflow)
);

// File: tb/hole_alloc_tb_top.sv
`timescale 1ns/1ps
module hole_alloc_tb_top;

    localparam int DEPTH  = 8;
    localparam int ADDR_W = 16;
    localparam int SIZE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [SIZE_W-1:0] req_size = '0;
    logic [1:0]        req_policy = 2'd0;
    logic              gnt_valid;
    logic              gnt_fail;
    logic [ADDR_W-1:0] gnt_base;
    logic              ret_valid = 1'b0;
    logic              ret_ready;
    logic [ADDR_W-1:0] ret_base = '0;
    logic [SIZE_W-1:0] ret_size = '0;
    logic              ret_overflow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    hole_alloc #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_policy(req_policy),
        .gnt_valid(gnt_valid), .gnt_fail(gnt_fail), .gnt_base(gnt_base),
        .ret_valid(ret_valid), .ret_ready(ret_ready),
        .ret_base(ret_base), .ret_size(ret_size),
        .ret_overflow(ret_overflow)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 5000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Return a hole; overflow is combinational and sampled before the edge.
    task automatic do_return(input string req, input int base, input int size, input bit exp_ovf);
        @(negedge clk);
        ret_valid = 1'b1;
        ret_base  = ADDR_W'(base);
        ret_size  = SIZE_W'(size);
        #1;
        check(req, "ret_ready", int'(ret_ready), 1);
        check(req, "ret_overflow", int'(ret_overflow), int'(exp_ovf));
        @(posedge clk);
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    // Request; lat counts edges after the accepting edge until gnt_valid.
    // When inject is set, a request and a large return are offered while busy.
    task automatic do_req(input string req, input int size, input int pol,
                          input bit exp_fail, input int exp_base, input int exp_lat,
                          input bit inject);
        int lat = 0;
        @(negedge clk);
        check(req, "req_ready idle", int'(req_ready), 1);
        req_valid  = 1'b1;
        req_size   = SIZE_W'(size);
        req_policy = 2'(pol);
        @(posedge clk);
        @(negedge clk);
        if (inject) begin
            req_size  = SIZE_W'(1);
            ret_valid = 1'b1;
            ret_base  = ADDR_W'(16'h0900);
            ret_size  = SIZE_W'(500);
            #1;
            check("R10", "ret_ready while busy", int'(ret_ready), 0);
            check("R10", "req_ready while busy", int'(req_ready), 0);
        end else begin
            req_valid = 1'b0;
        end
        while (!gnt_valid && lat < 20) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        ret_valid = 1'b0;
        check(req, "grant latency", lat, exp_lat);
        check(req, "gnt_fail", int'(gnt_fail), int'(exp_fail));
        if (!exp_fail) check(req, "gnt_base", int'(gnt_base), exp_base);
        @(posedge clk);
        @(negedge clk);
        check("R10", "gnt pulse ends", int'(gnt_valid), 0);
        check("R10", "ready after grant", int'(req_ready), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "req_ready", int'(req_ready), 1);
        check("R1", "ret_ready", int'(ret_ready), 1);
        check("R1", "gnt_valid", int'(gnt_valid), 0);
        do_req("R1", 1, 0, 1'b1, 0, DEPTH, 1'b0);
    endtask

    task automatic t_policies();
        do_return("R8", 16'h0100, 40, 1'b0);
        do_return("R8", 16'h0200, 10, 1'b0);
        do_return("R8", 16'h0300, 60, 1'b0);
        do_return("R8", 16'h0400, 10, 1'b0);
        do_return("R8", 16'h0500, 60, 1'b0);
        do_req("R3", 30, 0, 1'b0, 16'h0100, 1, 1'b0);
        do_req("R6", 10, 1, 1'b0, 16'h011E, DEPTH, 1'b0);
        do_req("R5", 20, 2, 1'b0, 16'h0300, DEPTH, 1'b1);
        do_req("R7", 50, 3, 1'b0, 16'h0500, 5, 1'b0);
        do_req("R2", 100, 2, 1'b1, 0, DEPTH, 1'b0);
        do_req("R2", 40, 0, 1'b0, 16'h0314, 3, 1'b0);
        do_req("R4", 10, 1, 1'b0, 16'h0200, DEPTH, 1'b0);
    endtask

    task automatic t_insert_and_full();
        do_return("R8", 16'h0700, 5, 1'b0);
        do_req("R8", 5, 0, 1'b0, 16'h0700, 1, 1'b0);
        for (int i = 0; i < 6; i++) do_return("R8", 16'h0800 + i * 16, 2, 1'b0);
        do_return("R9", 16'h0A00, 900, 1'b1);
        do_req("R9", 900, 2, 1'b1, 0, DEPTH, 1'b0);
        do_req("R5", 2, 2, 1'b0, 16'h0400, DEPTH, 1'b0);
        do_req("R4", 2, 1, 1'b0, 16'h0800, DEPTH, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_policies();
        t_insert_and_full();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule